// File: doc/BRIEF.md
# Register-Exchange Survivor Memory for a Four-State Viterbi Decoder

This block stores the surviving input-bit histories of a four-state, rate-1/2 Viterbi decoder. Each history is a shift register, one per trellis state. On every accepted symbol, the add-compare-select stage upstream supplies one decision bit per state and the index of the state that now has the smallest path metric. Each state's register then becomes a copy of its chosen predecessor's register, moved up by one place, with that state's own input bit written into the lowest cell. Path metrics are not computed here.

The decoder's estimate of an input bit comes out of the oldest cell, which is the most significant bit. It is read from the register of the best state and is released once the registers have been filled. After that, every accepted symbol releases one decoded bit. That bit belongs to the symbol absorbed DEPTH-1 symbols earlier. With the default DEPTH of 11, the k-th decoded bit appears with the (k+10)-th accepted symbol.

Top module: `rx_survivor_unit`

## Requirements
- R1: When reset is low at a clock edge, that edge clears every survivor register and the fill count. After reset, dec_valid is 0 and dec_bit is 0. A reset in the middle of a run means DEPTH new symbols must be absorbed before dec_valid rises again.
- R2: The state index is 2 bits. On an accepted symbol, new state s takes its history from predecessor {s[0], sel_dec[s]}. Decision 0 selects the predecessor whose low bit is 0. So states 0 and 2 choose between predecessors 0 and 1, and states 1 and 3 choose between predecessors 2 and 3.
- R3: The new register is the predecessor's bits [DEPTH-2:0] moved to [DEPTH-1:1], with s[1] written into bit 0. The predecessor's top bit is dropped. States 0 and 1 therefore append 0, and states 2 and 3 append 1.
- R4: dec_valid is a one-cycle pulse in the cycle after an accepted symbol. It pulses only if that symbol is the DEPTH-th or later accepted symbol since reset. It is 0 after every other edge.
- R5: While dec_valid is 1, dec_bit equals bit DEPTH-1 of the updated register of the state that best_state named with the same symbol.
- R6: An edge with sym_valid low changes no survivor register and does not advance the fill count.
- R7: Take a random bit stream encoded with generators 1+D+D^2 and 1+D^2, starting from state 0 and followed by zero tail bits. When it is decoded error-free through minimum-metric selection and this block, the output equals the input with no bit errors.
- R8: The same stream with one code bit inverted in every tenth symbol also decodes with no bit errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | Accept the decisions of one trellis step |
| sel_dec | input | 4 | Per-new-state decision bit; bit s belongs to state s |
| best_state | input | 2 | State with the smallest metric after this step |
| dec_valid | output | 1 | Decoded bit available |
| dec_bit | output | 1 | Decoded bit (oldest cell of the best state) |

## Verification
A behavioural queue model is compared with the block on every symbol. The model is driven with uniform decision vectors (all zeros, all ones), alternating vectors, and random vectors with random best-state indices. Uniform vectors confirm which way each selector points. Alternating vectors confirm that each state's choice is independent of the others. Random best-state indices confirm that the output is read from the indexed row and not from a fixed one. Idle gaps and a reset in mid-stream separate "hold" from "advance" and confirm the fill delay. Clean and sparsely corrupted encoded streams, decoded through a bench-side compare stage, show that the predecessor wiring matches the real trellis.

// File: rtl/rx_surv_pkg.sv
// Package: trellis helpers shared by the survivor-path modules.
// Assumes a shift-register encoder whose state is {newest input, older inputs}.
package rx_surv_pkg;

    // Lowest-numbered predecessor feeding new state 'st' (memory 'mem').
    function automatic int rx_pred_base(input int st, input int mem);
        return (st % (1 << (mem - 1))) * 2;
    endfunction

    // Input bit that drives the trellis into state 'st'.
    function automatic int rx_append_bit(input int st, input int mem);
        return (st >> (mem - 1)) & 1;
    endfunction

endpackage

// File: rtl/rx_path_row.sv
// Module: one survivor register (one trellis state).
// On an accepted symbol it loads the chosen predecessor's history moved up one
// place, with this state's input bit in bit 0. It holds otherwise.
// Assumes cand0/cand1 carry the two predecessors' low DEPTH-1 bits.
module rx_path_row
    import rx_surv_pkg::*;
#(
    parameter int DEPTH = 11,
    parameter int MEM   = 2,
    parameter int STATE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic             dec_bit,
    input  logic [DEPTH-2:0] cand0,
    input  logic [DEPTH-2:0] cand1,
    output logic [DEPTH-1:0] path_q
);
    localparam logic APPEND = 1'(rx_append_bit(STATE, MEM));

    logic [DEPTH-2:0] chosen;
    logic [DEPTH-1:0] path_d;

    // Select the surviving predecessor and append this state's bit.
    always_comb begin
        chosen = dec_bit ? cand1 : cand0;
        path_d = {chosen, APPEND};
    end

    // Survivor register: clear on reset, load on accepted symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)
            path_q <= '0;
        else if (sym_valid)
            path_q <= path_d;
    end

    // R6: idle cycles leave the register untouched
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(path_q));

    // R3: the newest cell always carries this state's input bit
    a_r3_append_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> path_q[0] == APPEND);

endmodule

// File: rtl/rx_fill_counter.sv
// Module: counts accepted symbols until the survivor registers are full.
// 'primed' is high when the current accepted symbol completes or follows the fill.
module rx_fill_counter #(
    parameter int DEPTH = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_valid,
    output logic primed
);
    localparam int CW = $clog2(DEPTH);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] cnt_q;

    // Saturating count of accepted symbols, capped at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (sym_valid && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    // Registers are full once DEPTH-1 symbols precede the current one.
    always_comb primed = (cnt_q == LAST);

    // R4: the fill count never runs past its cap
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R6: an idle edge never advances the count
    a_r6_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(cnt_q));

endmodule

// File: rtl/rx_out_select.sv
// Module: output stage. It registers the valid pulse and the best-state index,
// then reads the oldest cell of that state's (already updated) register.
module rx_out_select #(
    parameter int NUM_ST = 4,
    parameter int MEM    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    input  logic              primed,
    input  logic [MEM-1:0]    best_state,
    input  logic [NUM_ST-1:0] oldest,
    output logic              dec_valid,
    output logic              dec_bit
);
    logic [MEM-1:0] best_q;

    // Capture the best index with each accepted symbol; pulse when full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_q    <= '0;
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= sym_valid && primed;
            if (sym_valid)
                best_q <= best_state;
        end
    end

    // Oldest cell of the selected state.
    always_comb dec_bit = oldest[best_q];

    // R4: a decoded bit only follows an accepted symbol
    a_r4_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(sym_valid));

endmodule

// File: rtl/rx_survivor_unit.sv
// Module: register-exchange survivor memory for a 2^MEM-state Viterbi decoder.
// It takes one decision bit per state and the best-state index per symbol, and
// emits the oldest bit of the best state's history. Metrics are external.
module rx_survivor_unit
    import rx_surv_pkg::*;
#(
    parameter int DEPTH = 11,
    parameter int MEM   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sym_valid,
    input  logic [(1<<MEM)-1:0]   sel_dec,
    input  logic [MEM-1:0]        best_state,
    output logic                  dec_valid,
    output logic                  dec_bit
);
    localparam int NUM_ST = 1 << MEM;

    logic [DEPTH-1:0]  surv [NUM_ST];
    logic [NUM_ST-1:0] oldest;
    logic              primed;

    // One survivor row per state, wired to its two trellis predecessors.
    for (genvar s = 0; s < NUM_ST; s++) begin : g_row
        localparam int PB = rx_pred_base(s, MEM);
        rx_path_row #(.DEPTH(DEPTH), .MEM(MEM), .STATE(s)) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .sym_valid (sym_valid),
            .dec_bit   (sel_dec[s]),
            .cand0     (surv[PB][DEPTH-2:0]),
            .cand1     (surv[PB+1][DEPTH-2:0]),
            .path_q    (surv[s])
        );
        assign oldest[s] = surv[s][DEPTH-1];
    end

    rx_fill_counter #(.DEPTH(DEPTH)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .primed    (primed)
    );

    rx_out_select #(.NUM_ST(NUM_ST), .MEM(MEM)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_valid  (sym_valid),
        .primed     (primed),
        .best_state (best_state),
        .oldest     (oldest),
        .dec_valid  (dec_valid),
        .dec_bit    (dec_bit)
    );

    // R2: with decision 0, state 0 extends its own history (predecessor 0)
    a_r2_state0_keeps_self: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !sel_dec[0]) |=> surv[0][DEPTH-1:1] == $past(surv[0][DEPTH-2:0]));

    // R2: with decision 1, the top state extends its own history
    a_r2_top_keeps_self: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sel_dec[NUM_ST-1]) |=> surv[NUM_ST-1][DEPTH-1:1] == $past(surv[NUM_ST-1][DEPTH-2:0]));

endmodule

// File: tb/tb_rx_survivor_unit.sv
// Bench: queue-based reference model compared on every symbol, plus
// end-to-end decoding of encoded streams through a behavioural ACS stage.
module tb_rx_survivor_unit;
    localparam int DEPTH = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [3:0] sel_dec = '0;
    logic [1:0] best_state = '0;
    logic       dec_valid;
    logic       dec_bit;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    bit mq [4][$];
    int mcnt = 0;
    bit captured [$];

    always #2 clk = ~clk;

    rx_survivor_unit #(.DEPTH(DEPTH), .MEM(2)) dut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sel_dec(sel_dec),
        .best_state(best_state), .dec_valid(dec_valid), .dec_bit(dec_bit)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 4; s++) mq[s].delete();
        mcnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sym_valid = 1'b0;
        repeat (2) @(negedge clk);
        model_clear();
        rst_n = 1'b1;
    endtask

    // Drive one cycle at negedge, update model at posedge, compare at next negedge.
    task automatic step(input bit v, input logic [3:0] d, input logic [1:0] b);
        bit nq [4][$];
        bit ev;
        bit eb;
        sym_valid = v; sel_dec = d; best_state = b;
        @(posedge clk);
        ev = 0; eb = 0;
        if (v) begin
            for (int s = 0; s < 4; s++) begin
                int p = (s % 2) * 2 + int'(d[s]);
                nq[s] = mq[p];
                nq[s].push_back(bit'(s >> 1));
                if (nq[s].size() > DEPTH) void'(nq[s].pop_front());
            end
            for (int s = 0; s < 4; s++) mq[s] = nq[s];
            mcnt++;
            if (mcnt >= DEPTH) begin
                ev = 1;
                eb = mq[b][0];
            end
        end
        @(negedge clk);
        check(v ? "R4 valid timing" : "R6 idle no output", int'(dec_valid), int'(ev));
        if (ev) begin
            check("R5/R2/R3 decoded bit", int'(dec_bit), int'(eb));
            if (dec_valid) captured.push_back(dec_bit);
        end
    endtask

    // Encode, optionally corrupt, run a behavioural ACS and decode through the DUT.
    task automatic run_decode(input int n, input bit noisy, input string req);
        bit src [$];
        int pm [4];
        int npm [4];
        logic [3:0] dv;
        logic [1:0] es;
        int best;
        int errs;
        do_reset();
        captured.delete();
        for (int i = 0; i < n; i++) src.push_back(bit'($urandom_range(0, 1)));
        for (int i = 0; i < DEPTH + 1; i++) src.push_back(1'b0);
        pm[0] = 0; pm[1] = 20; pm[2] = 20; pm[3] = 20;
        es = 2'b00;
        for (int t = 0; t < src.size(); t++) begin
            bit u = src[t];
            bit r1 = u ^ es[1] ^ es[0];
            bit r2 = u ^ es[0];
            int mn;
            es = {u, es[1]};
            if (noisy && (t % 10 == 9)) begin
                if ((t / 10) % 2 == 0) r1 = ~r1; else r2 = ~r2;
            end
            for (int s = 0; s < 4; s++) begin
                int m0;
                int m1;
                bit us = bit'(s >> 1);
                bit hi = bit'(s % 2);
                m0 = pm[(s % 2) * 2]     + int'((us ^ hi ^ 1'b0) != r1) + int'((us ^ 1'b0) != r2);
                m1 = pm[(s % 2) * 2 + 1] + int'((us ^ hi ^ 1'b1) != r1) + int'((us ^ 1'b1) != r2);
                dv[s] = (m1 < m0);
                npm[s] = (m1 < m0) ? m1 : m0;
            end
            mn = npm[0]; best = 0;
            for (int s = 1; s < 4; s++) if (npm[s] < mn) begin mn = npm[s]; best = s; end
            for (int s = 0; s < 4; s++) pm[s] = npm[s] - mn;
            step(1'b1, dv, 2'(best));
        end
        check({req, " output count"}, captured.size(), src.size() - DEPTH + 1);
        errs = 0;
        for (int k = 0; k < captured.size() && k < n + 2; k++)
            if (captured[k] != src[k]) errs++;
        check({req, " bit errors"}, errs, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 reset dec_valid", int'(dec_valid), 0);
        check("R1 reset dec_bit", int'(dec_bit), 0);

        // R2/R3: uniform and alternating decision patterns, each best index
        for (int i = 0; i < 14; i++) step(1'b1, 4'b0000, 2'(i));
        for (int i = 0; i < 14; i++) step(1'b1, 4'b1111, 2'(i + 1));
        for (int i = 0; i < 14; i++) step(1'b1, (i % 2) ? 4'b1010 : 4'b0101, 2'(i + 2));
        // R5: random decisions and random best-state index
        for (int i = 0; i < 60; i++)
            step(1'b1, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)));
        // R6: idle gaps interleaved with symbols
        for (int i = 0; i < 30; i++) begin
            step(1'b0, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)));
            step(1'b1, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)));
        end

        // R1: reset mid-run restarts the fill delay
        do_reset();
        @(negedge clk);
        check("R1 mid-run reset dec_valid", int'(dec_valid), 0);
        for (int i = 0; i < DEPTH + 4; i++)
            step(1'b1, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)));

        run_decode(80, 1'b0, "R7 clean stream");
        run_decode(120, 1'b0, "R7 clean stream 2");
        run_decode(150, 1'b1, "R8 sparse errors");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule